// File: doc/BRIEF.md
# Total-Store-Order Memory Switch

This block models the memory side of a small multi-core system that keeps total store order. Several cores share one single-ported data memory. Every core owns a private first-in first-out store queue. A store leaves the core as soon as it is in that queue, and the queue drains into memory later. A round-robin switch hands the memory port to one core per cycle. The core that gets the port either performs its pending load or retires the oldest store in its queue.

A load whose address matches a store still queued in its own core takes the youngest matching value straight from the queue, without waiting for the port. A load with no match may go ahead of the stores queued before it. This store-then-load pair is the only ordering that may be relaxed; load-load, load-store and store-store order are all kept. An atomic swap waits until its own queue is empty, reads the old word, and writes the new word in the next cycle while the switch grants nobody.

Each core has two request channels, both valid/ready. Store requests are accepted while the queue has room and no load from that core is pending. Load and swap requests complete on the handshake cycle. A one-cycle response pulse follows, which cannot be back-pressured. A requester holds valid and its payload stable until ready.

Top module: `tso_switch`

## Requirements
- R1: After reset every memory word reads as zero, every store queue is empty (so store ready is high for every core), and no load ready or response is asserted.
- R2: A core's queued stores reach memory in the order they were accepted, so once the queue has drained, any core loading that address sees the last value stored to it.
- R3: When a core's store queue holds DEPTH entries, store ready for that core is low until an entry drains; no accepted store is lost.
- R4: At most one memory access (a load read, a queue drain or a swap write) happens in any cycle, and at most one core is granted.
- R5: A plain load whose address matches an entry in its own core's queue handshakes in the cycle it is presented and returns the youngest matching queued value.
- R6: A swap (load request with the swap flag set) is not accepted while its own queue holds entries. It returns the word's old value and leaves its write data in memory. No other core is granted in the cycle after its acceptance.
- R7: The switch grants cores in round-robin order starting after the last granted core, skipping cores with nothing to do; after reset core 0 has first priority.
- R8: The load response pulse, with its data, appears exactly one cycle after the load handshake.
- R9: A granted core that has a non-forwarding load ready performs the load before draining older queued stores. So with two cores each storing one address and then loading the other's address, both loads may return the old value zero.
- R10: While a core presents a load or swap, its store channel is not ready, so no later store can overtake a pending load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | NCORES | Store request valid, one bit per core |
| st_addr | input | NCORES*AW | Store word address per core |
| st_data | input | NCORES*DW | Store data per core |
| st_ready | output | NCORES | Store accepted into the queue this cycle |
| ld_valid | input | NCORES | Load or swap request valid per core |
| ld_addr | input | NCORES*AW | Load word address per core |
| ld_swap | input | NCORES | Request is an atomic swap |
| ld_wdata | input | NCORES*DW | Data written by a swap |
| ld_ready | output | NCORES | Load or swap handshake this cycle |
| rsp_valid | output | NCORES | Response pulse, one cycle after the handshake |
| rsp_data | output | NCORES*DW | Loaded value, or old value for a swap |

## Verification
Sequential single-operation vectors, each followed by enough idle cycles to drain every queue, set the plain memory semantics apart from any queueing effect. Stores pushed while two other cores keep the port busy fill a queue, which shows the back-pressure limit and youngest-match forwarding. A two-core store-then-load-the-other pattern gives the zero/zero outcome, which only a switch that lets loads pass queued stores produces. Simultaneous loads from all cores, and from a subset, show the rotation order and the skipping of idle cores. A swap issued behind a queued store to the same word shows that the swap waits for the drain rather than forwarding.

// File: rtl/tso_pkg.sv
package tso_pkg;
  // What a core does with the memory port in the current cycle
  typedef enum logic [1:0] {
    GK_IDLE  = 2'd0,
    GK_LOAD  = 2'd1,
    GK_DRAIN = 2'd2
  } grant_kind_e;
endpackage

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4   // power of two, at least 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] probe_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] head_q, tail_q;
  logic [PW:0]   cnt_q;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == (PW+1)'(DEPTH));
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // Walk oldest to youngest; the last match wins, giving the youngest store
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head_q + PW'(k);
      if (((PW+1)'(k) < cnt_q) && (addr_q[idx] == probe_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !(cnt_q > (PW+1)'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
endmodule

// File: rtl/tso_rr_arb.sv
module tso_rr_arb #(
  parameter int N = 3   // at least 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         hold,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    win_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && !hold && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (|gnt)    last_q <= win_idx;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R7
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (gnt == '0)); // R6
endmodule

// File: rtl/tso_switch.sv
module tso_switch
  import tso_pkg::*;
#(
  parameter int NCORES = 3,
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    st_valid,
  input  logic [NCORES*AW-1:0] st_addr,
  input  logic [NCORES*DW-1:0] st_data,
  output logic [NCORES-1:0]    st_ready,
  input  logic [NCORES-1:0]    ld_valid,
  input  logic [NCORES*AW-1:0] ld_addr,
  input  logic [NCORES-1:0]    ld_swap,
  input  logic [NCORES*DW-1:0] ld_wdata,
  output logic [NCORES-1:0]    ld_ready,
  output logic [NCORES-1:0]    rsp_valid,
  output logic [NCORES*DW-1:0] rsp_data
);
  localparam int WORDS = 1 << AW;

  logic [NCORES-1:0] wb_empty, wb_full, hit, ld_elig, fwd_take, req, gnt;
  logic [NCORES-1:0] sel_load, sel_drain, push;
  logic [AW-1:0]     ld_addr_a [NCORES];
  logic [AW-1:0]     head_addr [NCORES];
  logic [DW-1:0]     head_data [NCORES];
  logic [DW-1:0]     hit_data  [NCORES];
  logic [DW-1:0]     rsp_q     [NCORES];
  grant_kind_e       gk        [NCORES];

  logic              locked_q;
  logic [AW-1:0]     swap_addr_q;
  logic [DW-1:0]     swap_data_q;
  logic [DW-1:0]     mem_q [WORDS];

  logic              wr_en, rd_en, swap_go;
  logic [AW-1:0]     wr_addr, rd_addr, swap_addr;
  logic [DW-1:0]     wr_data, rd_data, swap_data;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    assign ld_addr_a[i] = ld_addr[i*AW +: AW];
    assign st_ready[i]  = !wb_full[i] && !ld_valid[i];
    assign push[i]      = st_valid[i] && st_ready[i];

    tso_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) wbuf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push[i]),
      .push_addr  (st_addr[i*AW +: AW]),
      .push_data  (st_data[i*DW +: DW]),
      .pop        (sel_drain[i]),
      .head_addr  (head_addr[i]),
      .head_data  (head_data[i]),
      .empty      (wb_empty[i]),
      .full       (wb_full[i]),
      .probe_addr (ld_addr_a[i]),
      .hit        (hit[i]),
      .hit_data   (hit_data[i])
    );

    // Plain loads with a queue match never need the port
    assign fwd_take[i] = ld_valid[i] && !ld_swap[i] && hit[i];
    // A swap only goes once its own queue has drained
    assign ld_elig[i]  = ld_valid[i] && !fwd_take[i] && (!ld_swap[i] || wb_empty[i]);
    assign req[i]      = ld_elig[i] || !wb_empty[i];

    assign gk[i] = !gnt[i]    ? GK_IDLE :
                   ld_elig[i] ? GK_LOAD : GK_DRAIN;
    assign sel_load[i]  = (gk[i] == GK_LOAD);
    assign sel_drain[i] = (gk[i] == GK_DRAIN);
    assign ld_ready[i]  = fwd_take[i] || sel_load[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[i] <= 1'b0;
        rsp_q[i]     <= '0;
      end else begin
        rsp_valid[i] <= ld_ready[i];
        if (ld_ready[i]) rsp_q[i] <= fwd_take[i] ? hit_data[i] : rd_data;
      end
    end
    assign rsp_data[i*DW +: DW] = rsp_q[i];

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ready[i] |=> rsp_valid[i]); // R8
    AST_SWAP_QUEUE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ready[i] && ld_swap[i]) |-> wb_empty[i]); // R6
  end

  tso_rr_arb #(.N(NCORES)) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .hold  (locked_q),
    .gnt   (gnt)
  );

  // Memory port mux: swap write phase, else the granted core's drain or read
  always_comb begin
    wr_en     = locked_q;
    wr_addr   = swap_addr_q;
    wr_data   = swap_data_q;
    rd_en     = 1'b0;
    rd_addr   = '0;
    swap_go   = 1'b0;
    swap_addr = '0;
    swap_data = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (sel_drain[i]) begin
        wr_en   = 1'b1;
        wr_addr = head_addr[i];
        wr_data = head_data[i];
      end
      if (sel_load[i]) begin
        rd_en   = 1'b1;
        rd_addr = ld_addr_a[i];
        if (ld_swap[i]) begin
          swap_go   = 1'b1;
          swap_addr = ld_addr_a[i];
          swap_data = ld_wdata[i*DW +: DW];
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q    <= 1'b0;
      swap_addr_q <= '0;
      swap_data_q <= '0;
    end else begin
      locked_q <= swap_go;
      if (swap_go) begin
        swap_addr_q <= swap_addr;
        swap_data_q <= swap_data;
      end
    end
  end

  AST_SINGLE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R4
  AST_LOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> !locked_q); // R6
  AST_LOCK_AFTER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |=> (locked_q && gnt == '0)); // R6
endmodule

// File: tb/tso_switch_tb.sv
module tso_switch_tb_top;
  localparam int N = 3, AW = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    st_valid = '0, ld_valid = '0, ld_swap = '0;
  logic [N*AW-1:0] st_addr = '0, ld_addr = '0;
  logic [N*DW-1:0] st_data = '0, ld_wdata = '0;
  logic [N-1:0]    st_ready, ld_ready, rsp_valid;
  logic [N*DW-1:0] rsp_data;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] refm [16];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  tso_switch #(.NCORES(N), .AW(AW), .DW(DW), .DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_swap(ld_swap), .ld_wdata(ld_wdata),
    .ld_ready(ld_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // {kind(0 store,1 load,2 swap), core, addr, data}
  localparam logic [15:0] VEC [12] = '{
    {2'd0, 2'd0, 4'd1, 8'h10}, {2'd0, 2'd1, 4'd2, 8'h20},
    {2'd1, 2'd2, 4'd1, 8'h00}, {2'd1, 2'd0, 4'd2, 8'h00},
    {2'd0, 2'd2, 4'd1, 8'h33}, {2'd1, 2'd1, 4'd1, 8'h00},
    {2'd2, 2'd1, 4'd2, 8'h44}, {2'd1, 2'd0, 4'd2, 8'h00},
    {2'd0, 2'd0, 4'd3, 8'hA5}, {2'd0, 2'd0, 4'd3, 8'h5A},
    {2'd1, 2'd2, 4'd3, 8'h00}, {2'd2, 2'd2, 4'd3, 8'h01}
  };

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; st_valid = '0; ld_valid = '0; ld_swap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 16; w++) refm[w] = 8'h00;
  endtask

  task automatic do_store(input int c, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    st_valid[c] = 1'b1; st_addr[c*AW +: AW] = a; st_data[c*DW +: DW] = d;
    #1;
    while (!st_ready[c]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid[c] = 1'b0;
  endtask

  task automatic do_load(input int c, input logic [3:0] a, input logic sw,
                         input logic [7:0] wd, output logic [7:0] d, output int waited);
    @(negedge clk);
    ld_valid[c] = 1'b1; ld_swap[c] = sw;
    ld_addr[c*AW +: AW] = a; ld_wdata[c*DW +: DW] = wd;
    waited = 0;
    #1;
    while (!ld_ready[c]) begin @(negedge clk); #1; waited++; end
    @(posedge clk); #1;
    ld_valid[c] = 1'b0; ld_swap[c] = 1'b0;
    @(negedge clk);
    check("R8 response one cycle after handshake", int'(rsp_valid[c]), 1);
    d = rsp_data[c*DW +: DW];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d0, d1, d2;
    int w0, w1, w2, acc;
    logic saw_full;

    do_reset();
    @(negedge clk); #1;
    check("R1 store ready after reset", int'(st_ready), 7);
    check("R1 no load ready after reset", int'(ld_ready), 0);
    check("R1 no response after reset", int'(rsp_valid), 0);
    do_load(1, 4'd3, 1'b0, 8'h00, d0, w0);
    check("R1 memory zero after reset", int'(d0), 0);

    // Table walk: one operation at a time with drain time between (R2, R6)
    for (int v = 0; v < 12; v++) begin
      logic [1:0] kind; int c; logic [3:0] a; logic [7:0] dv;
      kind = VEC[v][15:14]; c = int'(VEC[v][13:12]); a = VEC[v][11:8]; dv = VEC[v][7:0];
      if (kind == 2'd0) begin
        do_store(c, a, dv);
        refm[a] = dv;
      end else begin
        do_load(c, a, kind == 2'd2, dv, d0, w0);
        check(kind == 2'd2 ? "R6 swap returns old value" : "R2 load sees last store",
              int'(d0), int'(refm[a]));
        if (kind == 2'd2) refm[a] = dv;
      end
      repeat (4) @(negedge clk);
    end
    do_load(1, 4'd3, 1'b0, 8'h00, d0, w0);
    check("R6 swap data written", int'(d0), 1);

    // Forwarding from own queue, same-cycle handshake (R5)
    do_store(0, 4'd2, 8'h11);
    do_load(0, 4'd2, 1'b0, 8'h00, d0, w0);
    check("R5 forward value", int'(d0), 'h11);
    check("R5 forward without waiting", w0, 0);

    // Fill core 0 queue while cores 1 and 2 keep the port busy (R3, R5)
    repeat (3) @(negedge clk);
    @(negedge clk);
    ld_valid[1] = 1'b1; ld_addr[1*AW +: AW] = 4'd15;
    ld_valid[2] = 1'b1; ld_addr[2*AW +: AW] = 4'd15;
    acc = 0; saw_full = 1'b0;
    st_valid[0] = 1'b1; st_addr[0 +: AW] = 4'd5; st_data[0 +: DW] = 8'h30;
    for (int t = 0; t < 14; t++) begin
      #1;
      if (st_ready[0]) acc++; else saw_full = 1'b1;
      @(negedge clk);
      st_data[0 +: DW] = 8'(8'h30 + acc);
    end
    st_valid[0] = 1'b0;
    check("R3 queue full stalls store", int'(saw_full), 1);
    do_load(0, 4'd5, 1'b0, 8'h00, d0, w0);
    check("R5 youngest match forwarded", int'(d0), int'(8'(8'h30 + acc - 1)));
    check("R5 youngest forward without waiting", w0, 0);
    ld_valid[1] = 1'b0; ld_valid[2] = 1'b0;
    repeat (12) @(negedge clk);
    do_load(2, 4'd5, 1'b0, 8'h00, d0, w0);
    check("R3 no accepted store lost", int'(d0), int'(8'(8'h30 + acc - 1)));

    // Store buffering litmus: loads pass queued stores (R9)
    do_reset();
    fork
      do_store(0, 4'd8, 8'h01);
      do_store(1, 4'd9, 8'h01);
    join
    fork
      do_load(0, 4'd9, 1'b0, 8'h00, d0, w0);
      do_load(1, 4'd8, 1'b0, 8'h00, d1, w1);
    join
    check("R9 core0 load passes queued store", int'(d0), 0);
    check("R9 core1 load passes queued store", int'(d1), 0);
    repeat (6) @(negedge clk);
    do_load(2, 4'd8, 1'b0, 8'h00, d2, w2);
    check("R2 drained store visible", int'(d2), 1);

    // Round robin from reset and skipping idle cores (R7, R4)
    do_reset();
    fork
      do_load(0, 4'd0, 1'b0, 8'h00, d0, w0);
      do_load(1, 4'd1, 1'b0, 8'h00, d1, w1);
      do_load(2, 4'd2, 1'b0, 8'h00, d2, w2);
    join
    check("R7 core0 first after reset", w0, 0);
    check("R7 core1 second", w1, 1);
    check("R4 one grant per cycle, core2 third", w2, 2);
    fork
      do_load(0, 4'd0, 1'b0, 8'h00, d0, w0);
      do_load(2, 4'd2, 1'b0, 8'h00, d2, w2);
    join
    check("R7 core0 after core2 wraps", w0, 0);
    check("R7 idle core1 skipped", w2, 1);

    // Swap behind a queued store to the same word (R6, R10)
    do_store(0, 4'd7, 8'h55);
    fork
      do_load(0, 4'd7, 1'b1, 8'h99, d0, w0);
      begin
        @(negedge clk); #2;
        check("R10 store blocked while load pending", int'(st_ready[0]), 0);
      end
    join
    check("R6 swap waits for queue drain", w0, 1);
    check("R6 swap old value from drained store", int'(d0), 'h55);
    do_load(1, 4'd7, 1'b0, 8'h00, d1, w1);
    check("R6 swap new value visible", int'(d1), 'h99);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule